// File: doc/BRIEF.md
# Handshaked Shift-In/Shift-Out FIFO

This block is a synchronous first-in first-out buffer, 64 words deep and 9 bits wide by default. On the write side, a shift-in strobe is qualified by an input-ready flag. On the read side, a shift-out strobe is qualified by an output-ready flag. Both strobes are sampled on the rising clock edge. A strobe that arrives while its ready flag is low is discarded. Because of this, the write side can never overfill the buffer and the read side can never read it while it is empty.

The oldest stored word is always visible on the data output while output-ready is high. Two occupancy flags are derived from the word count:
- a half-full flag;
- a combined near-boundary flag, which is high when the buffer is close to empty or close to full.

A synchronous master reset empties the buffer. Stages chain in depth: the upstream output-ready feeds the downstream shift-in, and the downstream input-ready feeds the upstream shift-out.

Top module: `hs_fifo`

## Requirements
- R1: The buffer stores DEPTH words of WIDTH bits. From empty, exactly DEPTH shift-in strobes are accepted before input-ready falls.
- R2: `ir_o` is high exactly when fewer than DEPTH words are held, and `or_o` is high exactly when at least one word is held. Both flags reflect the count after the most recent clock edge.
- R3: A shift-in while `ir_o` is low, or a shift-out while `or_o` is low, changes neither the stored words nor the count.
- R4: Words leave in the order in which they were accepted.
- R5: When a shift-in and a shift-out are both accepted at the same edge, the count stays the same.
- R6: While `or_o` is high, `dout_o` shows the oldest stored word. It changes only after an accepted shift-out or a master reset.
- R7: `hf_o` is high when the count is DEPTH/2 (32) or more, and low otherwise.
- R8: `afe_o` is high when the count is MARGIN (8) or less, or is DEPTH-MARGIN (56) or more. It is low otherwise.
- R9: `mr_i` high at a clock edge empties the buffer and takes priority over both strobes. `rst_ni` clears the buffer asynchronously. After either one, `ir_o`=1, `or_o`=0, `hf_o`=0 and `afe_o`=1.
- R10: In a two-stage chain built with default parameters, where upstream `or_o` drives downstream `si_i` and downstream `ir_o` drives upstream `so_i`, the chain holds 2×DEPTH words and keeps their order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mr_i | input | 1 | Synchronous master reset |
| si_i | input | 1 | Shift-in strobe |
| din_i | input | WIDTH | Write data |
| ir_o | output | 1 | Input ready |
| so_i | input | 1 | Shift-out strobe |
| or_o | output | 1 | Output ready |
| dout_o | output | WIDTH | Oldest stored word |
| hf_o | output | 1 | Half-full flag |
| afe_o | output | 1 | Almost-full or almost-empty flag |

## Verification
The bench builds every instance with the defaults: WIDTH=9, DEPTH=64 and MARGIN=8. These values place the flag thresholds at 8, 32 and 56. A full fill followed by a full drain therefore walks through every occupancy level from 0 to 64, and each threshold crossing is seen in both directions. The 9-bit data width lets a 128-word cascade carry distinct words, so order checking across the stage boundary is unambiguous.

// File: rtl/hs_fifo_pkg.sv
package hs_fifo_pkg;
  typedef struct packed {
    logic clr;
    logic push;
    logic pop;
  } fifo_op_t;
endpackage

// File: rtl/hs_fifo_mem.sv
module hs_fifo_mem #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk_i) begin
      if (we_i && waddr_i == AW'(i)) mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/hs_fifo_ctrl.sv
module hs_fifo_ctrl
  import hs_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mr_i,
  input  logic          si_i,
  input  logic          so_i,
  output logic          ir_o,
  output logic          or_o,
  output fifo_op_t      op_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic [CW-1:0] count_o
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_P = AW'(DEPTH - 1);

  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  assign ir_o = cnt_q < FULL_C;
  assign or_o = cnt_q != '0;

  always_comb begin
    op_o.clr  = mr_i;
    op_o.push = si_i && ir_o && !mr_i;
    op_o.pop  = so_i && or_o && !mr_i;
  end

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == LAST_P) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (op_o.clr) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (op_o.push) wr_q <= nxt(wr_q);
      if (op_o.pop)  rd_q <= nxt(rd_q);
      unique case ({op_o.push, op_o.pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign wr_ptr_o = wr_q;
  assign rd_ptr_o = rd_q;
  assign count_o  = cnt_q;

  // R1: count bounded by capacity
  p_no_overflow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_C);

  // R3: shift-in while full is dropped
  p_full_ignore_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ir_o && si_i && !so_i && !mr_i) |=> $stable(cnt_q) && $stable(wr_q));

  // R3: shift-out while empty is dropped
  p_empty_ignore_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!or_o && so_i && !si_i && !mr_i) |=> $stable(cnt_q) && $stable(rd_q));

  // R5: concurrent accepted push and pop keep count
  p_simul_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (si_i && so_i && ir_o && or_o && !mr_i) |=> $stable(cnt_q));

  // R9: master reset empties
  p_mr_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mr_i |=> (cnt_q == '0) && (wr_q == rd_q));
endmodule

// File: rtl/hs_fifo_flags.sv
module hs_fifo_flags #(
  parameter int DEPTH  = 64,
  parameter int MARGIN = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] count_i,
  output logic          hf_o,
  output logic          afe_o
);
  localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);
  localparam logic [CW-1:0] LOW_C  = CW'(MARGIN);
  localparam logic [CW-1:0] HIGH_C = CW'(DEPTH - MARGIN);

  always_comb begin
    hf_o  = count_i >= HALF_C;
    afe_o = (count_i <= LOW_C) || (count_i >= HIGH_C);
  end
endmodule

// File: rtl/hs_fifo.sv
module hs_fifo
  import hs_fifo_pkg::*;
#(
  parameter int WIDTH  = 9,
  parameter int DEPTH  = 64,
  parameter int MARGIN = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mr_i,
  input  logic             si_i,
  input  logic [WIDTH-1:0] din_i,
  output logic             ir_o,
  input  logic             so_i,
  output logic             or_o,
  output logic [WIDTH-1:0] dout_o,
  output logic             hf_o,
  output logic             afe_o
);
  fifo_op_t      op;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  hs_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .mr_i, .si_i, .so_i,
    .ir_o, .or_o,
    .op_o(op), .wr_ptr_o(wr_ptr), .rd_ptr_o(rd_ptr), .count_o(count)
  );

  hs_fifo_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
    .clk_i,
    .we_i(op.push), .waddr_i(wr_ptr), .wdata_i(din_i),
    .raddr_i(rd_ptr), .rdata_o(dout_o)
  );

  hs_fifo_flags #(.DEPTH(DEPTH), .MARGIN(MARGIN)) u_flags (
    .count_i(count), .hf_o, .afe_o
  );

  // R6: head word holds until popped
  p_dout_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (or_o && !so_i && !mr_i) |=> or_o && $stable(dout_o));

  // R7: half-full implies data present
  p_hf_or_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hf_o |-> or_o);
endmodule

// File: tb/hs_fifo_tb.sv
`timescale 1ns/1ps
module hs_fifo_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic mr_i = 0, si_i = 0, so_i = 0;
  logic [8:0] din_i = '0;
  logic ir_o, or_o, hf_o, afe_o;
  logic [8:0] dout_o;

  hs_fifo u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mr_i(mr_i), .si_i(si_i), .din_i(din_i),
    .ir_o(ir_o), .so_i(so_i), .or_o(or_o), .dout_o(dout_o),
    .hf_o(hf_o), .afe_o(afe_o)
  );

  // two-stage cascade
  logic c_si = 0, c_so = 0;
  logic [8:0] c_din = '0;
  logic c_ir0, c_or0, c_ir1, c_or1, c_hf0, c_af0, c_hf1, c_af1;
  logic [8:0] c_d0, c_d1;

  hs_fifo u_c0 (
    .clk_i(clk), .rst_ni(rst_n), .mr_i(1'b0), .si_i(c_si), .din_i(c_din),
    .ir_o(c_ir0), .so_i(c_ir1), .or_o(c_or0), .dout_o(c_d0),
    .hf_o(c_hf0), .afe_o(c_af0)
  );
  hs_fifo u_c1 (
    .clk_i(clk), .rst_ni(rst_n), .mr_i(1'b0), .si_i(c_or0), .din_i(c_d0),
    .ir_o(c_ir1), .so_i(c_so), .or_o(c_or1), .dout_o(c_d1),
    .hf_o(c_hf1), .afe_o(c_af1)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [8:0] q[$];

  task automatic chk(input string what, input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (size %0d)", req, what, act, exp, q.size());
    end
  endtask

  task automatic compare();
    int n = q.size();
    chk("ir_o", "R2", ir_o, n < 64);
    chk("or_o", "R2", or_o, n > 0);
    chk("hf_o", "R7", hf_o, n >= 32);
    chk("afe_o", "R8", afe_o, (n <= 8) || (n >= 56));
    if (n > 0) chk("dout_o", "R4/R6", dout_o, q[0]);
  endtask

  task automatic step(input logic si, input logic so, input logic [8:0] d, input logic mr);
    si_i = si; so_i = so; din_i = d; mr_i = mr;
    @(posedge clk);
    if (mr) q.delete();
    else begin
      bit pop_ok  = so && q.size() > 0;
      bit push_ok = si && q.size() < 64;
      if (pop_ok) void'(q.pop_front());
      if (push_ok) q.push_back(d);
    end
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int acc;
    logic [8:0] k;
    repeat (3) @(negedge clk);
    compare(); // R9 async reset state
    rst_n = 1'b1;
    @(negedge clk);
    compare();

    // R1 fill to full, flags at every level
    for (int i = 0; i < 64; i++) step(1, 0, 9'(i * 7 + 3), 0);
    chk("full count", "R1", q.size(), 64);
    chk("ir_o at full", "R1", ir_o, 0);
    // R3 strobes ignored while full
    for (int i = 0; i < 3; i++) step(1, 0, 9'h1AA, 0);
    // R5 simultaneous at full: only pop accepted
    step(1, 1, 9'h055, 0);
    // drain past empty, R3 shift-out ignored while empty
    for (int i = 0; i < 68; i++) step(0, 1, 9'h000, 0);
    chk("or_o at empty", "R3", or_o, 0);

    // R5 simultaneous in/out at mid occupancy
    for (int i = 0; i < 20; i++) step(1, 0, 9'(i + 100), 0);
    for (int i = 0; i < 30; i++) begin
      step(1, 1, 9'(i + 200), 0);
      chk("steady count", "R5", q.size(), 20);
    end
    // simultaneous at empty: only push accepted
    for (int i = 0; i < 20; i++) step(0, 1, 9'h0, 0);
    step(1, 1, 9'h0F0, 0);
    chk("push at empty", "R5", q.size(), 1);

    // R6 hold without shift-out
    for (int i = 0; i < 5; i++) step(1, 0, 9'(i + 300), 0);
    for (int i = 0; i < 5; i++) step(0, 0, 9'h1FF, 0);

    // random mix
    for (int i = 0; i < 600; i++) step(1'($urandom_range(0, 2) != 0), 1'($urandom_range(0, 2) == 0), 9'($urandom), 0);
    for (int i = 0; i < 400; i++) step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) != 0), 9'($urandom), 0);

    // R9 master reset beats strobes
    for (int i = 0; i < 40; i++) step(1, 0, 9'(i), 0);
    step(1, 1, 9'h077, 1);
    chk("count after mr", "R9", q.size(), 0);
    chk("or_o after mr", "R9", or_o, 0);
    step(1, 0, 9'h123, 0);

    // R10 cascade fill
    acc = 0; k = '0;
    for (int i = 0; i < 200; i++) begin
      bit take;
      c_si = 1; c_din = k;
      take = c_ir0;
      @(posedge clk);
      if (take) begin q.push_back(k); acc++; k = k + 1'b1; end
      @(negedge clk);
    end
    c_si = 0;
    repeat (5) @(negedge clk);
    chk("cascade capacity", "R10", acc, 128);
    chk("cascade ir", "R10", c_ir0, 0);
    // drop single-dut leftovers: keep only cascade words
    while (q.size() > 128) void'(q.pop_front());
    for (int i = 0; i < 140; i++) begin
      c_so = 1;
      if (c_or1) chk("cascade order", "R10", c_d1, (q.size() > 0) ? int'(q.pop_front()) : -1);
      @(posedge clk);
      @(negedge clk);
    end
    c_so = 0;
    chk("cascade drained", "R10", q.size(), 0);
    chk("cascade or", "R10", c_or1, 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule